// File: doc/BRIEF.md
# In-Order Issue Stage with Register and Write-Port Reservations

This block is the issue stage of a pipeline that feeds several pipelined functional units with different fixed latencies. Instructions arrive already decoded, one per cycle, over a valid/ready handshake. Each one carries an operation class, two source register indices and a destination index. Issue is strictly in program order, but results may complete out of order: a short operation issued after a long one can write back first.

Two records of state settle every hazard before an instruction leaves. The first is a reserved flag for each architectural register. It covers read-after-write and write-after-write conflicts on the sources and the destination. The second is a shifting vector of future cycles on the single shared register write port. The class of an instruction fixes how many cycles after issue it will write. The instruction may leave only if that future cycle is still free.

On issue, operand values are read from a simple register array and sent out together with the class and the destination tag. An internal delay line then marks the cycle of writeback. In that cycle the block shows which register is being written, accepts the result value, stores it, and releases the register's flag.

Top module: `issue_resv_unit`

## Requirements
- R1: After reset no register is reserved, no write-port cycle is claimed, `wb_valid` is low, every register reads as zero, and any legal instruction is accepted at once.
- R2: `iss_valid` equals `in_valid && in_ready`. While it is high, `iss_cls` and `iss_dst` repeat the presented fields, and `in_cls` is never 3.
- R3: `in_ready` is low while either source register of the presented instruction is reserved.
- R4: `in_ready` is low while the destination register of the presented instruction is reserved.
- R5: Class 0 writes 1 cycle after issue, class 1 writes 3 cycles after issue, and class 2 writes 6 cycles after issue. `in_ready` is low when that write-port cycle is already claimed by an earlier instruction.
- R6: An instruction issued in cycle c raises `wb_valid`, with `wb_dst` equal to its destination, in exactly cycle c plus its class latency. `wb_valid` is high in no other cycle.
- R7: `iss_opa` and `iss_opb` carry the current register contents. A register holds the `wb_data` value presented in the cycle of its last writeback.
- R8: Issuing an instruction reserves its destination register. The reservation is released by that register's writeback, and a dependent instruction can first issue in the cycle after the writeback.
- R9: Completion can be out of order: a class 0 instruction issued one cycle after a class 2 instruction writes back 4 cycles before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Presented instruction is valid |
| in_ready | output | 1 | No hazard blocks the presented instruction |
| in_cls | input | 2 | Operation class (0, 1 or 2) |
| in_src_a | input | 3 | First source register index |
| in_src_b | input | 3 | Second source register index |
| in_dst | input | 3 | Destination register index |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_cls | output | 2 | Class of the issued instruction |
| iss_opa | output | 16 | First operand value |
| iss_opb | output | 16 | Second operand value |
| iss_dst | output | 3 | Destination tag of the issued instruction |
| wb_valid | output | 1 | Write port in use this cycle |
| wb_dst | output | 3 | Register written this cycle |
| wb_data | input | 16 | Result value sampled when wb_valid is high |

## Verification
The properties rely on two facts about the inputs. The class field never carries the unused code 3. A held instruction keeps its fields unchanged until it is accepted. The stimulus meets both: it draws classes only from 0 to 2, and each instruction it presents stays fixed, cycle after cycle, until the ready output rises. It then sweeps every pair of classes across independent, source-dependent and destination-dependent register patterns, and every spacing between a long operation and a later one that could collide with it on the write port.

// File: rtl/issue_resv_pkg.sv
package issue_resv_pkg;
   typedef enum logic [1:0] {
      CLS_SHORT = 2'd0,
      CLS_MID   = 2'd1,
      CLS_LONG  = 2'd2
   } op_cls_e;

   localparam int NUM_CLS = 3;
endpackage

// File: rtl/reg_busy_table.sv
module reg_busy_table #(
   parameter int NREG = 8,
   localparam int IW = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [IW-1:0]   set_idx,
   input  logic            clr_en,
   input  logic [IW-1:0]   clr_idx,
   output logic [NREG-1:0] busy
);
   for (genvar g = 0; g < NREG; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            busy[g] <= 1'b0;
         else if (set_en && set_idx == IW'(g))
            busy[g] <= 1'b1;
         else if (clr_en && clr_idx == IW'(g))
            busy[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/wport_resv_shifter.sv
module wport_resv_shifter #(
   parameter int RESV_W = 8,
   parameter int IW     = 3,
   localparam int SW = $clog2(RESV_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              claim_en,
   input  logic [SW-1:0]     claim_lat,
   input  logic [IW-1:0]     claim_dst,
   output logic [RESV_W-1:0] resv,
   output logic              head_valid,
   output logic [IW-1:0]     head_dst
);
   logic          slot_v [RESV_W];
   logic [IW-1:0] slot_d [RESV_W];

   for (genvar g = 0; g < RESV_W; g++) begin : g_slot
      logic          up_v;
      logic [IW-1:0] up_d;
      if (g < RESV_W - 1) begin : g_mid
         assign up_v = slot_v[g+1];
         assign up_d = slot_d[g+1];
      end else begin : g_top
         assign up_v = 1'b0;
         assign up_d = '0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_v[g] <= 1'b0;
            slot_d[g] <= '0;
         end else if (claim_en && claim_lat == SW'(g + 1)) begin
            slot_v[g] <= 1'b1;
            slot_d[g] <= claim_dst;
         end else begin
            slot_v[g] <= up_v;
            slot_d[g] <= up_d;
         end
      end
      assign resv[g] = slot_v[g];
   end

   assign head_valid = slot_v[0];
   assign head_dst   = slot_d[0];
endmodule

// File: rtl/reg_array.sv
module reg_array #(
   parameter int NREG = 8,
   parameter int DW   = 16,
   localparam int IW = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_a_idx,
   input  logic [IW-1:0] rd_b_idx,
   output logic [DW-1:0] rd_a,
   output logic [DW-1:0] rd_b
);
   logic [DW-1:0] mem [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en && wr_idx == IW'(g))
            mem[g] <= wr_data;
      end
   end

   assign rd_a = mem[rd_a_idx];
   assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/issue_resv_unit.sv
module issue_resv_unit
   import issue_resv_pkg::*;
#(
   parameter int NREG      = 8,
   parameter int DW        = 16,
   parameter int RESV_W    = 8,
   parameter int LAT_SHORT = 1,
   parameter int LAT_MID   = 3,
   parameter int LAT_LONG  = 6,
   localparam int IW = $clog2(NREG),
   localparam int SW = $clog2(RESV_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [1:0]    in_cls,
   input  logic [IW-1:0] in_src_a,
   input  logic [IW-1:0] in_src_b,
   input  logic [IW-1:0] in_dst,
   output logic          iss_valid,
   output logic [1:0]    iss_cls,
   output logic [DW-1:0] iss_opa,
   output logic [DW-1:0] iss_opb,
   output logic [IW-1:0] iss_dst,
   output logic          wb_valid,
   output logic [IW-1:0] wb_dst,
   input  logic [DW-1:0] wb_data
);
   if (NREG < 2) begin : g_bad_nreg
      $error("NREG must be at least 2");
   end
   if (LAT_SHORT < 1 || LAT_MID < 1 || LAT_LONG < 1) begin : g_bad_lat_lo
      $error("every class latency must be at least 1");
   end
   if (LAT_SHORT >= RESV_W || LAT_MID >= RESV_W || LAT_LONG >= RESV_W) begin : g_bad_lat_hi
      $error("class latency must be below RESV_W");
   end

   logic [NREG-1:0]   busy_vec;
   logic [RESV_W-1:0] resv_vec;
   logic [SW-1:0]     lat_sel;
   logic              haz_src, haz_dst, haz_port;
   logic              issue_fire;
   op_cls_e           cls_e;

   assign cls_e = op_cls_e'(in_cls);

   always_comb begin
      case (cls_e)
         CLS_SHORT: lat_sel = SW'(LAT_SHORT);
         CLS_MID:   lat_sel = SW'(LAT_MID);
         default:   lat_sel = SW'(LAT_LONG);
      endcase
   end

   assign haz_src    = busy_vec[in_src_a] | busy_vec[in_src_b];
   assign haz_dst    = busy_vec[in_dst];
   assign haz_port   = resv_vec[lat_sel];
   assign in_ready   = !(haz_src || haz_dst || haz_port);
   assign issue_fire = in_valid && in_ready;

   reg_busy_table #(.NREG(NREG)) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (issue_fire),
      .set_idx (in_dst),
      .clr_en  (wb_valid),
      .clr_idx (wb_dst),
      .busy    (busy_vec)
   );

   wport_resv_shifter #(.RESV_W(RESV_W), .IW(IW)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim_en   (issue_fire),
      .claim_lat  (lat_sel),
      .claim_dst  (in_dst),
      .resv       (resv_vec),
      .head_valid (wb_valid),
      .head_dst   (wb_dst)
   );

   reg_array #(.NREG(NREG), .DW(DW)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wb_valid),
      .wr_idx   (wb_dst),
      .wr_data  (wb_data),
      .rd_a_idx (in_src_a),
      .rd_b_idx (in_src_b),
      .rd_a     (iss_opa),
      .rd_b     (iss_opb)
   );

   assign iss_valid = issue_fire;
   assign iss_cls   = in_cls;
   assign iss_dst   = in_dst;
endmodule

// File: rtl/issue_resv_chk.sv
module issue_resv_chk #(
   parameter int NREG      = 8,
   parameter int LAT_SHORT = 1,
   localparam int IW = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [1:0]      in_cls,
   input logic [IW-1:0]   in_src_a,
   input logic [IW-1:0]   in_src_b,
   input logic [IW-1:0]   in_dst,
   input logic            iss_valid,
   input logic            wb_valid,
   input logic [IW-1:0]   wb_dst,
   input logic [NREG-1:0] busy
);
   p_cls_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> in_cls != 2'd3);

   p_issue_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> in_valid);

   p_src_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> (!busy[in_src_a] && !busy[in_src_b]));

   p_dst_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> !busy[in_dst]);

   p_wb_to_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> busy[wb_dst]);

   p_wb_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !busy[$past(wb_dst)]);

   p_issue_reserves_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> busy[$past(in_dst)]);

   if (LAT_SHORT == 1) begin : g_short
      p_short_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && in_cls == 2'd0) |=> (wb_valid && wb_dst == $past(in_dst)));
   end
endmodule

bind issue_resv_unit issue_resv_chk #(.NREG(NREG), .LAT_SHORT(LAT_SHORT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_cls    (in_cls),
   .in_src_a  (in_src_a),
   .in_src_b  (in_src_b),
   .in_dst    (in_dst),
   .iss_valid (iss_valid),
   .wb_valid  (wb_valid),
   .wb_dst    (wb_dst),
   .busy      (busy_vec)
);

// File: tb/issue_resv_unit_bench.sv
module issue_resv_unit_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_cls = '0;
   logic [2:0]  in_src_a = '0, in_src_b = '0, in_dst = '0;
   logic        iss_valid;
   logic [1:0]  iss_cls;
   logic [15:0] iss_opa, iss_opb;
   logic [2:0]  iss_dst;
   logic        wb_valid;
   logic [2:0]  wb_dst;
   logic [15:0] wb_data = '0;

   issue_resv_unit u_issue_resv_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_cls(in_cls), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
      .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_opa(iss_opa), .iss_opb(iss_opb),
      .iss_dst(iss_dst), .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
   );

   always #(CLK_P/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // bench reference state, built from the requirements
   bit          m_busy [8];
   bit          m_sv   [8];
   logic [2:0]  m_sd   [8];
   logic [15:0] m_rf   [8];
   int          wb_cyc [8];

   function automatic int lat_of(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 3 : 6;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [1:0] c, input logic [2:0] a,
                       input logic [2:0] b, input logic [2:0] d, output bit fired);
      int          l;
      bit          e_rdy;
      string       tag;
      logic [15:0] wd;
      @(negedge clk);
      in_valid = v; in_cls = c; in_src_a = a; in_src_b = b; in_dst = d;
      wd = 16'h5A00 ^ 16'(cyc);
      wb_data = wd;
      #1;
      l = lat_of(c);
      e_rdy = !m_busy[a] && !m_busy[b] && !m_busy[d] && !m_sv[l];
      if (m_busy[a] || m_busy[b]) tag = "R3";
      else if (m_busy[d]) tag = "R4";
      else if (m_sv[l]) tag = "R5";
      else tag = "R2";
      chk(in_ready == e_rdy, tag, "in_ready", 32'(in_ready), 32'(e_rdy));
      chk(iss_valid == (v && e_rdy), "R2", "iss_valid", 32'(iss_valid), 32'(v && e_rdy));
      chk(wb_valid == m_sv[0], "R6", "wb_valid", 32'(wb_valid), 32'(m_sv[0]));
      if (m_sv[0])
         chk(wb_dst == m_sd[0], "R6", "wb_dst", 32'(wb_dst), 32'(m_sd[0]));
      if (v && e_rdy) begin
         chk(iss_opa == m_rf[a], "R7", "iss_opa", 32'(iss_opa), 32'(m_rf[a]));
         chk(iss_opb == m_rf[b], "R7", "iss_opb", 32'(iss_opb), 32'(m_rf[b]));
         chk(iss_dst == d && iss_cls == c, "R2", "iss_dst/cls",
             {27'd0, iss_cls, iss_dst}, {27'd0, c, d});
      end
      fired = v && e_rdy;
      @(posedge clk);
      if (m_sv[0]) begin
         m_rf[m_sd[0]] = wd;
         m_busy[m_sd[0]] = 1'b0;
         wb_cyc[m_sd[0]] = cyc;
      end
      for (int i = 0; i < 7; i++) begin
         m_sv[i] = m_sv[i+1];
         m_sd[i] = m_sd[i+1];
      end
      m_sv[7] = 1'b0;
      if (fired) begin
         m_sv[l-1] = 1'b1;
         m_sd[l-1] = d;
         m_busy[d] = 1'b1;
      end
      cyc++;
   endtask

   task automatic push(input logic [1:0] c, input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] d, output int t_iss);
      bit f = 1'b0;
      for (int k = 0; k < 40 && !f; k++) begin
         t_iss = cyc;
         step(1'b1, c, a, b, d, f);
      end
      chk(f, "R2", "instruction never issued", 32'(f), 32'd1);
   endtask

   task automatic idle(input int n);
      bit f;
      for (int k = 0; k < n; k++) step(1'b0, 2'd0, 3'd0, 3'd0, 3'd0, f);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog all actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int t0, t1;
      for (int i = 0; i < 8; i++) begin
         m_busy[i] = 0; m_sv[i] = 0; m_sd[i] = '0; m_rf[i] = '0; wb_cyc[i] = -1;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen at the ports
      in_valid = 1'b1; in_cls = 2'd2; in_src_a = 3'd3; in_src_b = 3'd5; in_dst = 3'd7;
      #1;
      chk(in_ready == 1'b1, "R1", "ready after reset", 32'(in_ready), 32'd1);
      chk(wb_valid == 1'b0, "R1", "wb_valid after reset", 32'(wb_valid), 32'd0);
      chk(iss_opa == 16'd0 && iss_opb == 16'd0, "R1", "operands after reset",
          {iss_opa, iss_opb}, 32'd0);
      in_valid = 1'b0;
      idle(1);

      // sweep: class pairs against register relationships
      for (int c1 = 0; c1 < 3; c1++)
         for (int c2 = 0; c2 < 3; c2++)
            for (int rel = 0; rel < 4; rel++) begin
               logic [2:0] a2, b2, d2;
               a2 = 3'd6; b2 = 3'd7; d2 = 3'd2;
               if (rel == 1) a2 = 3'd1;
               if (rel == 2) b2 = 3'd1;
               if (rel == 3) d2 = 3'd1;
               push(2'(c1), 3'd6, 3'd7, 3'd1, t0);
               push(2'(c2), a2, b2, d2, t1);
               idle(8);
            end

      // sweep: write-port collisions after a long operation
      for (int g = 0; g < 7; g++)
         for (int c2 = 0; c2 < 3; c2++) begin
            push(2'd2, 3'd4, 3'd4, 3'd1, t0);
            idle(g);
            push(2'(c2), 3'd1 + 3'd1, 3'd4, 3'd3, t1);
            // R5: a class whose write cycle equals the long one waits one cycle
            if (g + 1 + lat_of(2'(c2)) == 6 && g + 1 < 6)
               chk(t1 == t0 + g + 2, "R5", "collision delay", 32'(t1 - t0), 32'(g + 2));
            idle(8);
         end

      // R8: dependent instruction waits until the cycle after writeback
      push(2'd2, 3'd0, 3'd0, 3'd3, t0);
      push(2'd0, 3'd3, 3'd0, 3'd4, t1);
      chk(t1 - t0 == 7, "R8", "dependent issue distance", 32'(t1 - t0), 32'd7);
      idle(4);
      // R7: read back the written value
      push(2'd1, 3'd3, 3'd4, 3'd5, t1);
      idle(6);

      // R9: out-of-order completion
      push(2'd2, 3'd0, 3'd0, 3'd5, t0);
      push(2'd0, 3'd0, 3'd0, 3'd6, t1);
      idle(8);
      chk(t1 == t0 + 1, "R9", "short issues next cycle", 32'(t1 - t0), 32'd1);
      chk(wb_cyc[6] == t0 + 2, "R9", "short writeback cycle", 32'(wb_cyc[6] - t0), 32'd2);
      chk(wb_cyc[5] == t0 + 6, "R9", "long writeback cycle", 32'(wb_cyc[5] - t0), 32'd6);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule